// File: doc/BRIEF.md
# Read-Modify-Write Bus Cycle Sequencer

This block drives the data phase of a read-modify-write memory instruction on an 8-bit processor with a 16-bit address bus. A start strobe hands it the effective address. It then runs three bus cycles against that one address. The first cycle reads the operand. The middle cycle depends on the mode. The last cycle writes the result that the ALU computes from the held operand. Opcode decode, address generation and the ALU sit outside the block.

Two behaviours can be selected. In legacy mode the middle cycle is a write of the unmodified operand. Status registers that clear a bit when a 1 is written to it depend on this side effect. In modern mode the middle cycle is a second read of the same address, so only the final result reaches memory. A lock output marks the whole three-cycle window as one indivisible access. A one-cycle done pulse follows the final write.

Top module: `rmw_seq_unit`

## Requirements
- R1: With mode_legacy=1 sampled at start, the three data-phase cycles are read (rw_n=1), write (rw_n=0), write (rw_n=0), with no stall.
- R2: With mode_legacy=0 sampled at start, the three data-phase cycles are read, read, write.
- R3: In legacy mode, wr_data in the middle write equals the byte that was on rd_data at the end of the first read cycle.
- R4: In the final cycle, wr_data equals alu_result, and rw_n=0.
- R5: bus_addr equals the address captured with the accepted start, in every data-phase cycle and until the next accepted start.
- R6: lock_n is 0 during all three data-phase cycles and 1 otherwise. When no sequence runs, rw_n=1, wr_data=0 and busy=0.
- R7: While rdy=0 in a read cycle, the sequencer stays in that cycle and keeps its address. rdy has no effect during a write cycle.
- R8: A start strobe while busy=1 is ignored. Neither the address nor the sequence changes.
- R9: The mode is captured at start. A change on mode_legacy during a sequence has no effect on it.
- R10: done is 1 for exactly the one cycle after the final write. A start in that cycle is accepted.
- R11: operand shows the byte captured in the first read, and holds it until the next first read completes. The second read in modern mode does not replace it.
- R12: After synchronous reset (rst_n=0 at a clock edge): lock_n=1, rw_n=1, busy=0, done=0, bus_addr=0, operand=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a sequence at start_addr (taken only when idle) |
| start_addr | input | ADDR_W | Effective address of the operand |
| mode_legacy | input | 1 | 1: read, write, write; 0: read, read, write |
| rdy | input | 1 | Memory ready; 0 stretches read cycles |
| rd_data | input | DATA_W | Read data bus |
| alu_result | input | DATA_W | Modified value from the ALU |
| bus_addr | output | ADDR_W | Address bus |
| wr_data | output | DATA_W | Write data bus |
| rw_n | output | 1 | 1 = read cycle, 0 = write cycle |
| lock_n | output | 1 | Active-low indivisible-access marker |
| operand | output | DATA_W | Held operand for the ALU |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse after the final write |

## Verification
The bench builds the block with its default widths: a 16-bit address and an 8-bit data bus. At these widths it can place sequences at the top and bottom of the address space. It can also reproduce the case of an increment turning 0xF9 into 0xFA against a modelled status register in which writing a 1 clears the bit. In legacy mode that access clears bit 0; in modern mode the bit stays set. Stretched reads, ignored starts, mode changes in the middle of a sequence and back-to-back sequences are driven both in directed runs and in a random run. Each cycle is compared with a behavioural reference model.

// File: rtl/rmw_seq_pkg.sv
// Shared types for the read-modify-write sequencer.
package rmw_seq_pkg;

    // Phase of the data portion of a read-modify-write access.
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,  // no sequence in progress
        PH_FETCH  = 2'd1,  // first read of the operand
        PH_MID    = 2'd2,  // dead cycle: echo write (legacy) or reread (modern)
        PH_COMMIT = 2'd3   // final write of the ALU result
    } rmw_phase_e;

endpackage

// File: rtl/rmw_phase_ctrl.sv
// Phase controller: steps through fetch, mid and commit, captures the mode
// at start and raises done after commit.
// Assumes: start is taken only in PH_IDLE; rdy stalls read cycles only.
module rmw_phase_ctrl
    import rmw_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       mode_legacy,
    input  logic       rdy,
    output rmw_phase_e phase,
    output logic       legacy_q,
    output logic       accept,
    output logic       capture,
    output logic       done
);

    rmw_phase_e phase_nx;

    // Purpose: a start is accepted only when no sequence runs.
    always_comb accept = start && (phase == PH_IDLE);

    // Purpose: the operand is latched when the first read completes.
    always_comb capture = (phase == PH_FETCH) && rdy;

    // Purpose: next-phase selection; only read cycles wait on rdy.
    always_comb begin
        phase_nx = phase;
        unique case (phase)
            PH_IDLE:   if (start) phase_nx = PH_FETCH;
            PH_FETCH:  if (rdy) phase_nx = PH_MID;
            PH_MID:    if (legacy_q || rdy) phase_nx = PH_COMMIT;
            PH_COMMIT: phase_nx = PH_IDLE;
            default:   phase_nx = PH_IDLE;
        endcase
    end

    // Purpose: phase, mode and done registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            legacy_q <= 1'b0;
            done     <= 1'b0;
        end else begin
            phase <= phase_nx;
            done  <= (phase == PH_COMMIT);
            if (accept) legacy_q <= mode_legacy;
        end
    end

    AST_COMMIT_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_COMMIT) |=> (phase == PH_IDLE) && done); // R7

    AST_LEGACY_MID_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_MID && legacy_q) |=> (phase == PH_COMMIT)); // R1

    AST_MODE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_IDLE && $past(phase) != PH_IDLE) |-> $stable(legacy_q)); // R9

endmodule

// File: rtl/rmw_operand_hold.sv
// Operand and address store: keeps the effective address from start and the
// byte from the first read, for the whole sequence.
// Assumes: accept and capture never coincide (different phases).
module rmw_operand_hold #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              capture,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] operand_q
);

    // Purpose: hold the effective address from an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n)      addr_q <= '0;
        else if (accept) addr_q <= start_addr;
    end

    // Purpose: hold the operand from the first read only.
    always_ff @(posedge clk) begin
        if (!rst_n)       operand_q <= '0;
        else if (capture) operand_q <= rd_data;
    end

    AST_OPERAND_FROM_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> (operand_q == $past(rd_data))); // R11

endmodule

// File: rtl/rmw_bus_drive.sv
// Bus driver: derives address, write data, read/write and lock from the phase.
// Assumes: addr_q and operand_q are stable during a sequence.
module rmw_bus_drive
    import rmw_seq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  rmw_phase_e        phase,
    input  logic              legacy_q,
    input  logic [ADDR_W-1:0] addr_q,
    input  logic [DATA_W-1:0] operand_q,
    input  logic [DATA_W-1:0] alu_result,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              rw_n,
    output logic              lock_n
);

    logic echo_wr;

    // Purpose: the mid cycle becomes a write only in legacy mode.
    always_comb echo_wr = (phase == PH_MID) && legacy_q;

    // Purpose: all cycles address the captured effective address.
    always_comb bus_addr = addr_q;

    // Purpose: read/write strobe and lock marker per phase.
    always_comb begin
        rw_n   = !(echo_wr || (phase == PH_COMMIT));
        lock_n = (phase == PH_IDLE);
    end

    // Purpose: echo the operand in the dead write, the ALU value in commit.
    always_comb begin
        if (phase == PH_COMMIT) wr_data = alu_result;
        else if (echo_wr)       wr_data = operand_q;
        else                    wr_data = '0;
    end

endmodule

// File: rtl/rmw_seq_unit.sv
// Read-modify-write sequencer top: runs the three data-phase cycles against
// one effective address, in legacy (read, write, write) or modern
// (read, read, write) order.
// Assumes: the ALU derives alu_result combinationally from operand.
module rmw_seq_unit
    import rmw_seq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              mode_legacy,
    input  logic              rdy,
    input  logic [DATA_W-1:0] rd_data,
    input  logic [DATA_W-1:0] alu_result,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              rw_n,
    output logic              lock_n,
    output logic [DATA_W-1:0] operand,
    output logic              busy,
    output logic              done
);

    rmw_phase_e        phase;
    logic              legacy_q;
    logic              accept;
    logic              capture;
    logic [ADDR_W-1:0] addr_q;

    rmw_phase_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .mode_legacy(mode_legacy),
        .rdy        (rdy),
        .phase      (phase),
        .legacy_q   (legacy_q),
        .accept     (accept),
        .capture    (capture),
        .done       (done)
    );

    rmw_operand_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .start_addr(start_addr),
        .capture   (capture),
        .rd_data   (rd_data),
        .addr_q    (addr_q),
        .operand_q (operand)
    );

    rmw_bus_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_drive (
        .phase     (phase),
        .legacy_q  (legacy_q),
        .addr_q    (addr_q),
        .operand_q (operand),
        .alu_result(alu_result),
        .bus_addr  (bus_addr),
        .wr_data   (wr_data),
        .rw_n      (rw_n),
        .lock_n    (lock_n)
    );

    // Purpose: busy flags any phase other than idle.
    always_comb busy = (phase != PH_IDLE);

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!lock_n && $past(!lock_n)) |-> $stable(bus_addr)); // R5

    AST_LOCK_OPENS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock_n) |-> rw_n); // R6

    AST_DEAD_WRITE_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_MID && !rw_n) |-> (wr_data == $past(rd_data))); // R3

    AST_READ_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!lock_n && rw_n && !rdy) |=> ($stable(bus_addr) && !lock_n && rw_n)); // R7

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy) |=> $stable(bus_addr)); // R8

    AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(!rw_n) && $past(!lock_n))); // R10

endmodule

// File: tb/test_rmw_seq_unit.sv
`timescale 1ns/1ps
module test_rmw_seq_unit;

    localparam int AW = 16;
    localparam int DW = 8;
    localparam logic [AW-1:0] STAT_ADDR = 16'hD019;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic          mode_legacy = 1'b0;
    logic          rdy = 1'b1;
    logic [DW-1:0] rd_data;
    logic [DW-1:0] alu_result;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] wr_data;
    logic          rw_n, lock_n, busy, done;
    logic [DW-1:0] operand;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // Modelled status register: writing a 1 to a bit clears it
    logic [DW-1:0] stat = '0;
    logic [DW-1:0] stat_val = '0;
    bit            stat_set = 0;
    bit            alu_xor = 0;

    always #2.5 clk = ~clk;

    // Memory model and ALU (increment, or xor for a second pattern)
    always_comb rd_data = (bus_addr == STAT_ADDR) ? stat : (bus_addr[7:0] ^ bus_addr[15:8] ^ 8'h5A);
    always_comb alu_result = alu_xor ? (operand ^ 8'hA5) : (operand + 8'd1);

    rmw_seq_unit #(.ADDR_W(AW), .DATA_W(DW)) i_rmw_seq_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .mode_legacy(mode_legacy), .rdy(rdy), .rd_data(rd_data),
        .alu_result(alu_result), .bus_addr(bus_addr), .wr_data(wr_data),
        .rw_n(rw_n), .lock_n(lock_n), .operand(operand), .busy(busy), .done(done)
    );

    // Reference model: 0 idle, 1 first read, 2 middle cycle, 3 final write
    int            m_ph = 0;
    logic [AW-1:0] m_addr = '0;
    bit            m_leg = 0;
    logic [DW-1:0] m_op = '0;
    bit            m_done = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph <= 0; m_addr <= '0; m_leg <= 0; m_op <= '0; m_done <= 0;
        end else begin
            m_done <= (m_ph == 3);
            if (m_ph == 0) begin
                if (start) begin m_ph <= 1; m_addr <= start_addr; m_leg <= mode_legacy; end
            end else if (m_ph == 1) begin
                if (rdy) begin m_ph <= 2; m_op <= rd_data; end
            end else if (m_ph == 2) begin
                if (m_leg || rdy) m_ph <= 3;
            end else begin
                m_ph <= 0;
            end
        end
        if (stat_set) stat <= stat_val;
        else if (rst_n && !rw_n && bus_addr == STAT_ADDR) stat <= stat & ~wr_data;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare all outputs against the model in the current cycle
    task automatic compare();
        bit            e_wr;
        logic [DW-1:0] e_wd;
        e_wr = (m_ph == 3) || (m_ph == 2 && m_leg);
        e_wd = (m_ph == 3) ? alu_result : ((m_ph == 2 && m_leg) ? m_op : '0);
        chk(rw_n == !e_wr, "R1 R2 rw_n order", rw_n, !e_wr);
        chk(wr_data == e_wd, "R3 R4 wr_data", wr_data, e_wd);
        chk(bus_addr == m_addr, "R5 R8 bus_addr", bus_addr, m_addr);
        chk(lock_n == (m_ph == 0), "R6 lock_n", lock_n, m_ph == 0);
        chk(busy == (m_ph != 0), "R7 R9 busy/phase", busy, m_ph != 0);
        chk(done == m_done, "R10 done", done, m_done);
        chk(operand == m_op, "R11 operand", operand, m_op);
    endtask

    // One cycle: drive inputs after the falling edge, then compare
    task automatic step(input bit s, input logic [AW-1:0] a, input bit leg, input bit r);
        @(negedge clk);
        start = s; start_addr = a; mode_legacy = leg; rdy = r;
        #1;
        compare();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 16'h0, 0, 1);
    endtask

    initial begin
        int lf;
        // R12: reset state
        repeat (4) @(posedge clk);
        @(negedge clk); #1;
        chk(lock_n == 1 && rw_n == 1 && busy == 0 && done == 0, "R12 reset controls", {lock_n, rw_n, busy, done}, 4'b1100);
        chk(bus_addr == 0 && operand == 0, "R12 reset data", {bus_addr, operand}, 0);
        @(negedge clk); rst_n = 1;
        idle(2);

        // R1 R3 R4: legacy sequence at a low address
        step(1, 16'h1234, 1, 1); idle(5);
        // R2: modern sequence at the top of the address space
        step(1, 16'hFFFF, 0, 1); idle(5);
        // R7: stretched first read in legacy mode
        step(1, 16'h0000, 1, 1); step(0, 0, 1, 0); step(0, 0, 1, 0); step(0, 0, 1, 0); idle(5);
        // R7: stretched second read in modern mode
        step(1, 16'h8001, 0, 1); step(0, 0, 0, 1); step(0, 0, 0, 0); step(0, 0, 0, 0); idle(5);
        // R7: rdy low during write cycles has no effect
        step(1, 16'h4242, 1, 1); step(0, 0, 1, 1); step(0, 0, 1, 0); step(0, 0, 1, 0); idle(4);
        // R8: start while busy ignored; R9: mode flips mid-sequence
        step(1, 16'h1111, 0, 1); step(1, 16'h2222, 1, 1); step(1, 16'h3333, 1, 1); step(1, 16'h4444, 0, 1);
        // R10: start in the done cycle is accepted
        step(1, 16'h5555, 1, 1); idle(6);
        alu_xor = 1;
        step(1, 16'h00AA, 1, 1); idle(5);
        alu_xor = 0;

        // Status register: increment of 0xF9 writes 0 to bit 0
        @(negedge clk); stat_set = 1; stat_val = 8'hF9; @(negedge clk); stat_set = 0;
        step(1, STAT_ADDR, 1, 1); idle(5);
        chk(stat[0] == 1'b0, "R3 legacy dead write clears bit 0", stat, 0);
        @(negedge clk); stat_set = 1; stat_val = 8'hF9; @(negedge clk); stat_set = 0;
        step(1, STAT_ADDR, 0, 1); idle(5);
        chk(stat[0] == 1'b1, "R2 modern leaves bit 0 set", stat, 8'h01);

        // Random run
        lf = 32'h1ACE;
        for (int i = 0; i < 400; i++) begin
            lf = (lf << 1) ^ (((lf >> 15) ^ (lf >> 13)) & 1);
            step(lf[2], lf[15:0] ^ 16'h3C3C, lf[5], lf[3] | lf[7]);
        end

        // R12: synchronous reset mid-sequence
        step(1, 16'h9999, 1, 1);
        @(negedge clk); rst_n = 0; @(negedge clk); #1;
        chk(lock_n == 1 && busy == 0 && bus_addr == 0, "R12 reset mid-sequence", {lock_n, busy}, 2'b10);
        rst_n = 1; idle(2);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule